// File: doc/BRIEF.md
# Interrupt Cause, Mask and Aggregation Unit

This block collects interrupt causes for a network controller. Single-cycle event pulses from the datapath set bits in a 32-bit cause register. The bits stay set until software acknowledges them. A mask register chooses which causes may drive the single level-sensitive interrupt line. Bit 24 of the cause register is a summary bit. It reads as 1 whenever any cause in a fixed group of miscellaneous causes is pending.

Software reaches the block through one register port. The port has a write strobe, a write address and data, and a separate combinational read address. Acknowledging the summary bit also clears every cause it summarizes. This matters when a grouped cause is masked: if only the summary bit were cleared, the pending grouped cause would raise the summary bit again straight away and the interrupt would repeat forever.

An optional auto-mask feature removes selected mask bits at the moment software acknowledges an asserted interrupt.

Top module: `irq_cause_unit`

## Requirements
- R1: After a synchronous active-low reset, the cause, mask, auto-mask and control registers read 0 and `irq_o` is low.
- R2: An `evt_i` pulse on any bit other than 24 and 31 sets that cause bit. The bit stays set in later cycles with no further pulse.
- R3: A write to address 0 (cause) clears each cause bit written as 1 and leaves bits written as 0 unchanged.
- R4: Cause bit 24 reads 1 exactly when at least one of cause bits 2, 6, 9, 16, 17, 18 is set. Bit 24 therefore stays 1 after a clear while a grouped cause is still pending.
- R5: A cause write with data bit 24 set also clears cause bits 2, 6, 9, 16, 17 and 18 in the same cycle, even where they were written as 0.
- R6: `irq_o` is high exactly when cause bits 30..0 ANDed with mask bits 30..0 are nonzero. This includes the case where bit 24 is enabled and the underlying grouped cause is masked. Mask bit 31 has no effect on `irq_o`.
- R7: Cause bit 31 reads the current level of `irq_o`.
- R8: A write to address 1 (cause-set) ORs the data into cause bits 30..0, excluding bit 24.
- R9: A write to address 2 (mask-set) ORs the data into the mask. A write to address 3 (mask-clear) clears the mask bits written as 1. Reads at addresses 2 and 3 return the mask.
- R10: Address 4 holds the auto-mask value and address 5 the control word; control bit 0 enables auto-mask. A cause write made while `irq_o` is high and control bit 0 is 1 clears the mask bits that are set in the auto-mask register. With bit 0 at 0, or with `irq_o` low, the mask is untouched.
- R11: If an event pulse and a cause-write clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 32 | Event pulses, one bit per cause |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt line |

## Verification
The checker checks these properties on every cycle:
- the consistency between the summary bit and the grouped bits on the read port;
- the interrupt line being low straight after reset;
- write-one-to-clear on the cause register;
- the grouped clear triggered by acknowledging bit 24;
- events persisting across a same-cycle clear;
- mask-set;
- the auto-mask clear.

Only the bench scenarios can show the interrupt storm scenario end to end: a masked receive overrun keeps the line high through the summary bit, and a single acknowledge of bit 24 silences it. The scenarios also show the cases where auto-mask must not act, the cause-set path, and the fact that mask bit 31 is ignored. Each of these depends on a specific order of register writes.

// File: rtl/irq_cause_pkg.sv
// Package: shared constants for the interrupt cause unit.
// Assumes a 32-bit register file. Bit positions are fixed because software
// decodes them.
package irq_cause_pkg;
    localparam int REG_W       = 32;
    localparam int SUMMARY_BIT = 24;
    localparam int LEVEL_BIT   = 31;
    localparam int AUTO_EN_BIT = 0;
    // Causes folded into the summary bit: 2, 6, 9, 16, 17, 18
    localparam logic [REG_W-1:0] GROUP_MASK = (32'h1 << 2) | (32'h1 << 6) | (32'h1 << 9) |
                                              (32'h1 << 16) | (32'h1 << 17) | (32'h1 << 18);
    // Bits that are derived rather than stored
    localparam logic [REG_W-1:0] STORE_MASK = ~((32'h1 << SUMMARY_BIT) | (32'h1 << LEVEL_BIT));

    typedef enum logic [2:0] {
        A_CAUSE   = 3'd0,
        A_CSET    = 3'd1,
        A_MSET    = 3'd2,
        A_MCLR    = 3'd3,
        A_AUTOMSK = 3'd4,
        A_CTRL    = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/cause_store.sv
// Module: cause_store
// Holds the stored cause bits (every bit except summary and level).
// Assumes the set and clear vectors never come from the same write.
// Events are applied last so that they win over a clear.
module cause_store
    import irq_cause_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    output logic [REG_W-1:0] raw_q
);
    logic [REG_W-1:0] raw_n;

    // Next cause value: set, then clear, then events on top
    always_comb begin
        raw_n = (((raw_q | set_vec) & ~clr_vec) | evt) & STORE_MASK;
    end

    // Cause register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_n;
    end
endmodule

// File: rtl/mask_store.sv
// Module: mask_store
// Holds the mask, auto-mask and control registers.
// Auto-mask applies on a cause write while the line is high and enabled.
// Assumes one register write per cycle.
module mask_store
    import irq_cause_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              irq_now,
    output logic [REG_W-1:0]  mask_q,
    output logic [REG_W-1:0]  am_q,
    output logic [REG_W-1:0]  ctrl_q
);
    logic [REG_W-1:0] mask_n, am_n, ctrl_n;

    // Next-state selection for the mask-side registers
    always_comb begin
        mask_n = mask_q;
        am_n   = am_q;
        ctrl_n = ctrl_q;
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_W'(A_CAUSE):   if (irq_now && ctrl_q[AUTO_EN_BIT]) mask_n = mask_q & ~am_q;
                ADDR_W'(A_MSET):    mask_n = mask_q | wr_data;
                ADDR_W'(A_MCLR):    mask_n = mask_q & ~wr_data;
                ADDR_W'(A_AUTOMSK): am_n   = wr_data;
                ADDR_W'(A_CTRL):    ctrl_n = wr_data;
                default: ;
            endcase
        end
    end

    // Register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            am_q   <= '0;
            ctrl_q <= '0;
        end else begin
            mask_q <= mask_n;
            am_q   <= am_n;
            ctrl_q <= ctrl_n;
        end
    end
endmodule

// File: rtl/irq_aggregate.sv
// Module: irq_aggregate
// Derives the software-visible cause word and the interrupt level.
// The level uses bits 30..0 only, so the level bit cannot feed back on itself.
module irq_aggregate
    import irq_cause_pkg::*;
(
    input  logic [REG_W-1:0] raw,
    input  logic [REG_W-1:0] mask,
    output logic [REG_W-1:0] view,
    output logic             irq
);
    logic [REG_W-1:0] with_sum;
    logic [LEVEL_BIT-1:0] pend;

    // Fold the grouped causes into the summary bit
    always_comb begin
        with_sum = raw;
        with_sum[SUMMARY_BIT] = |(raw & GROUP_MASK);
    end

    // Per-bit pending terms
    for (genvar i = 0; i < LEVEL_BIT; i++) begin : g_pend
        assign pend[i] = with_sum[i] & mask[i];
    end

    // Line level and visible word
    always_comb begin
        irq  = |pend;
        view = with_sum;
        view[LEVEL_BIT] = irq;
    end
endmodule

// File: rtl/irq_cause_unit.sv
// Module: irq_cause_unit (top)
// Interrupt cause, mask and aggregation unit.
// Decodes register writes, builds the grouped clear and muxes reads.
// Assumes a synchronous active-low reset and a combinational read port.
module irq_cause_unit
    import irq_cause_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  evt_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq_o
);
    logic [REG_W-1:0] raw_q, mask_q, am_q, ctrl_q, view;
    logic [REG_W-1:0] set_vec, clr_vec;
    logic             cause_wr;

    // Write decode for cause-set and cause clear (with grouped clear)
    always_comb begin
        cause_wr = wr_en && (wr_addr == ADDR_W'(A_CAUSE));
        set_vec  = (wr_en && (wr_addr == ADDR_W'(A_CSET))) ? wr_data : '0;
        clr_vec  = '0;
        if (cause_wr)
            clr_vec = wr_data | (wr_data[SUMMARY_BIT] ? GROUP_MASK : '0);
    end

    cause_store u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_i),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .raw_q   (raw_q)
    );

    mask_store #(.ADDR_W(ADDR_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .irq_now (irq_o),
        .mask_q  (mask_q),
        .am_q    (am_q),
        .ctrl_q  (ctrl_q)
    );

    irq_aggregate u_agg (
        .raw  (raw_q),
        .mask (mask_q),
        .view (view),
        .irq  (irq_o)
    );

    // Read multiplexer
    always_comb begin
        unique case (rd_addr)
            ADDR_W'(A_CAUSE):   rd_data = view;
            ADDR_W'(A_MSET),
            ADDR_W'(A_MCLR):    rd_data = mask_q;
            ADDR_W'(A_AUTOMSK): rd_data = am_q;
            ADDR_W'(A_CTRL):    rd_data = ctrl_q;
            default:            rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_cause_unit_chk.sv
// Module: irq_cause_unit_chk
// Property checker bound to irq_cause_unit. It only observes.
module irq_cause_unit_chk
    import irq_cause_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  evt_i,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [REG_W-1:0]  rd_data,
    input logic              irq_o,
    input logic [REG_W-1:0]  raw_q,
    input logic [REG_W-1:0]  mask_q,
    input logic [REG_W-1:0]  am_q,
    input logic [REG_W-1:0]  ctrl_q
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o);

    // R4
    summary_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(A_CAUSE)) |-> (rd_data[SUMMARY_BIT] == |(rd_data & GROUP_MASK)));

    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(A_CAUSE) && evt_i == '0)
        |=> ((raw_q & $past(wr_data) & STORE_MASK) == '0));

    // R5
    group_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(A_CAUSE) && wr_data[SUMMARY_BIT] && evt_i == '0)
        |=> ((raw_q & GROUP_MASK) == '0));

    // R11
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((raw_q & $past(evt_i) & STORE_MASK) == ($past(evt_i) & STORE_MASK)));

    // R9
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(A_MSET)) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

    // R10
    auto_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(A_CAUSE) && irq_o && ctrl_q[AUTO_EN_BIT])
        |=> ((mask_q & $past(am_q)) == '0));
endmodule

bind irq_cause_unit irq_cause_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq_o   (irq_o),
    .raw_q   (raw_q),
    .mask_q  (mask_q),
    .am_q    (am_q),
    .ctrl_q  (ctrl_q)
);

// File: tb/sim_irq_cause_unit.sv
`timescale 1ns/1ps
module sim_irq_cause_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // Reference state
    logic [31:0] m_cause, m_mask, m_am, m_ctrl;
    localparam logic [31:0] GRP = 32'h0007_0244;

    always #4 clk = ~clk;

    irq_cause_unit u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    function automatic logic [31:0] m_view();
        logic [31:0] v;
        v = m_cause;
        v[24] = (m_cause & GRP) != 0;
        v[31] = ((v & m_mask) & 32'h7FFF_FFFF) != 0;
        return v;
    endfunction

    function automatic logic m_irq();
        logic [31:0] v;
        v = m_view();
        return v[31];
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        cmp({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_irq()});
        rd_addr = 3'd0; #1; cmp({tag, " cause"}, rd_data, m_view());
        rd_addr = 3'd2; #1; cmp({tag, " mask"},  rd_data, m_mask);
        rd_addr = 3'd4; #1; cmp({tag, " automask"}, rd_data, m_am);
        rd_addr = 3'd5; #1; cmp({tag, " ctrl"},  rd_data, m_ctrl);
    endtask

    // One clock: drive at negedge, update model after the edge, compare at next negedge
    task automatic step(input string tag, input logic [31:0] ev, input logic we,
                        input logic [2:0] a, input logic [31:0] d);
        logic [31:0] clr;
        evt_i = ev; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        if (we) begin
            case (a)
                3'd0: begin
                    if (m_irq() && m_ctrl[0]) m_mask = m_mask & ~m_am;
                    clr = d;
                    if (d[24]) clr = clr | GRP;
                    m_cause = m_cause & ~clr;
                end
                3'd1: m_cause = m_cause | d;
                3'd2: m_mask = m_mask | d;
                3'd3: m_mask = m_mask & ~d;
                3'd4: m_am = d;
                3'd5: m_ctrl = d;
                default: ;
            endcase
        end
        m_cause = (m_cause | ev) & 32'h7EFF_FFFF;
        @(negedge clk);
        evt_i = '0; wr_en = 1'b0;
        compare_all(tag);
    endtask

    task automatic idle(input string tag);
        step(tag, 32'h0, 1'b0, 3'd0, 32'h0);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        m_cause = '0; m_mask = '0; m_am = '0; m_ctrl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1 reset");

        // R2: event sets and holds
        step("R2 event", 32'h0000_0020, 0, 3'd0, 0);
        idle("R2 hold");
        // R9: mask set raises line, mask clear drops it
        step("R9 mset", 0, 1, 3'd2, 32'h0000_0020);
        step("R9 mclr", 0, 1, 3'd3, 32'h0000_0020);
        // R3: w1c touches only ones
        step("R3 ev", 32'h0000_0808, 0, 3'd0, 0);
        step("R3 w1c", 0, 1, 3'd0, 32'h0000_0020);
        // R5/R6 storm: masked overrun drives line through summary bit
        step("R6 ovr", 32'h0000_0040, 0, 3'd0, 0);
        step("R6 sum-en", 0, 1, 3'd2, 32'h0100_0000);
        idle("R6 storm");
        step("R5 ack", 0, 1, 3'd0, 32'h0100_0000);
        idle("R5 quiet");
        // R4: summary stays while a grouped cause remains
        step("R4 ev", 32'h0002_0004, 0, 3'd0, 0);
        step("R4 part", 0, 1, 3'd0, 32'h0000_0004);
        step("R4 last", 0, 1, 3'd0, 32'h0002_0000);
        // R8: cause-set incl. grouped bit
        step("R8 cset", 0, 1, 3'd1, 32'h0001_0001);
        step("R3 clr", 0, 1, 3'd0, 32'h0001_0809);
        // R6/R7: mask bit 31 alone has no effect
        step("R6 m31", 0, 1, 3'd2, 32'h8000_0000);
        step("R7 ev", 32'h8100_0000, 0, 3'd0, 0);
        // R10: auto-mask disabled, then enabled
        step("R10 am", 0, 1, 3'd4, 32'h0100_0000);
        step("R10 ev", 32'h0000_0200, 0, 3'd0, 0);
        step("R10 off", 0, 1, 3'd0, 32'h0000_0000);
        step("R10 en", 0, 1, 3'd5, 32'h0000_0001);
        step("R10 on", 0, 1, 3'd0, 32'h0000_0000);
        step("R10 low-mset", 0, 1, 3'd2, 32'h0100_0000);
        step("R10 clr", 0, 1, 3'd0, 32'h0100_0000);
        step("R10 idle-ack", 0, 1, 3'd0, 32'h0000_0000);
        // R11: event beats clear in same cycle
        step("R11 set", 32'h0000_0008, 0, 3'd0, 0);
        step("R11 race", 32'h0000_0008, 1, 3'd0, 32'h0000_0008);
        step("R11 done", 0, 1, 3'd0, 32'h0000_0008);
        // R1: reset mid-run clears everything
        step("R2 pre", 32'h0004_0000, 0, 3'd0, 0);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_cause = '0; m_mask = '0; m_am = '0; m_ctrl = '0;
        compare_all("R1 rereset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule